// File: doc/BRIEF.md
# Trigger pattern sequencer and recorder

This block holds a memory with one entry per clock period and runs it in one of two modes. In play mode it steps through the memory from entry 0 and drives each stored word onto a set of synchronous trigger and pre-trigger lines, one bit per line. This makes a test sequence repeatable to the exact cycle. In record mode it samples a set of outgoing synchronous trigger lines on every clock and writes each sample into consecutive entries, so software can read the result back and check it.

The host loads and reads the memory through a simple word port. It also selects the mode, the run length and the loop option. A start pulse begins a run. A run ends when the programmed length is used up, when the last entry has been processed, or when a stop pulse arrives, whichever happens first. A done flag then reports that the run has finished. Asynchronous signals cannot be played or recorded. The memory depth is a parameter, and a full-size instance uses 14 address bits.

Top module: `trig_seq_rec`

## Requirements
- R1: After reset, busy_o, done_o, play_vld_o, play_o and host_rdata_o are all 0.
- R2: While no run is active, a host write (host_en_i=1, host_we_i=1) stores host_wdata_i at host_addr_i. A host read (host_en_i=1, host_we_i=0) places the entry at host_addr_i on host_rdata_o one clock after the request edge, and host_rdata_o keeps that value until the next accepted read.
- R3: A start_i sampled while idle sets busy_o and clears done_o at that same edge. done_o then stays set until the next accepted start.
- R4: In play mode (mode_i=0), entry k is shown on play_o with play_vld_o=1 during the clock that follows edge S+k+1, where S is the edge that accepted the start.
- R5: A run covers N entries starting at entry 0. N is len_i, except that len_i=0 or len_i greater than the depth gives the full depth. busy_o falls and done_o rises at edge S+N.
- R6: In record mode (mode_i=1), entry k receives the value of rec_i sampled at edge S+k+1. Entries beyond the run are left unchanged.
- R7: When stop_i is sampled while busy, no entry is processed at that edge, busy_o falls, done_o rises, and play_vld_o is 0 in the next cycle.
- R8: With loop_i=1 in play mode, the entry after the last one of the run is entry 0 again, and the run continues until a stop. In record mode loop_i has no effect.
- R9: Host writes and reads requested while busy are ignored: memory contents are not changed and host_rdata_o holds its value.
- R10: A start_i sampled while busy has no effect; the running sequence continues and ends as programmed.
- R11: play_o is 0 in every cycle in which play_vld_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 play, 1 record; sampled at start |
| loop_i | input | 1 | Wrap to entry 0 in play mode; sampled at start |
| len_i | input | ADDR_W+1 | Run length in entries; 0 selects full depth |
| start_i | input | 1 | Start pulse |
| stop_i | input | 1 | Stop pulse |
| rec_i | input | DATA_W | Synchronous trigger lines to record |
| play_o | output | DATA_W | Played pattern |
| play_vld_o | output | 1 | play_o carries a stored entry |
| busy_o | output | 1 | Run active |
| done_o | output | 1 | Last run has ended |
| host_en_i | input | 1 | Host access request |
| host_we_i | input | 1 | 1 write, 0 read |
| host_addr_i | input | ADDR_W | Host entry address |
| host_wdata_i | input | DATA_W | Host write data |
| host_rdata_o | output | DATA_W | Host read data |

## Verification
Each result has a fixed latency. busy_o and done_o change at the edge that accepts a start, a stop or the last entry. Played entry k appears k+1 edges after the start edge. A host read returns one edge after its request, and a recorded sample lands at the edge where its entry is processed. The bench drives inputs and samples outputs on the falling edge. It counts rising edges from the accepted start, so every comparison falls in the cycle in which the value is due. Recorded data and ignored host writes are checked afterwards by host reads while idle.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
  typedef enum logic {
    MODE_PLAY = 1'b0,
    MODE_REC  = 1'b1
  } seq_mode_e;
endpackage

// File: rtl/trig_seq_mem.sv
module trig_seq_mem #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/trig_seq_ctrl.sv
module trig_seq_ctrl
  import trig_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  seq_mode_e         mode_i,
  input  logic              loop_i,
  input  logic [ADDR_W:0]   len_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              play_en_o,
  output logic              rec_we_o,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam int unsigned   DEPTH    = 1 << ADDR_W;
  localparam logic [ADDR_W:0]   DEPTH_L  = (ADDR_W+1)'(DEPTH);
  localparam logic [ADDR_W-1:0] LAST_IDX = {ADDR_W{1'b1}};

  logic              busy_q, done_q, loop_q;
  seq_mode_e         mode_q;
  logic [ADDR_W-1:0] ptr_q, last_q, last_d;
  logic              proc;

  // last processed index of the run
  assign last_d = (len_i == '0 || len_i > DEPTH_L) ? LAST_IDX
                                                    : ADDR_W'(len_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      loop_q <= 1'b0;
      mode_q <= MODE_PLAY;
      ptr_q  <= '0;
      last_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
        ptr_q  <= '0;
        last_q <= last_d;
        mode_q <= mode_i;
        loop_q <= loop_i;
      end
    end else if (stop_i) begin
      busy_q <= 1'b0;
      done_q <= 1'b1;
    end else if (ptr_q == last_q) begin
      if (loop_q && mode_q == MODE_PLAY) begin
        ptr_q <= '0;
      end else begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  assign proc      = busy_q & ~stop_i;
  assign play_en_o = proc & (mode_q == MODE_PLAY);
  assign rec_we_o  = proc & (mode_q == MODE_REC);
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign ptr_o     = ptr_q;
endmodule

// File: rtl/trig_seq_rec.sv
module trig_seq_rec
  import trig_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              loop_i,
  input  logic [ADDR_W:0]   len_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [DATA_W-1:0] rec_i,
  output logic [DATA_W-1:0] play_o,
  output logic              play_vld_o,
  output logic              busy_o,
  output logic              done_o,
  input  logic              host_en_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o
);
  logic              busy, play_en, rec_we, host_ok, mem_we;
  logic [ADDR_W-1:0] ptr, mem_waddr;
  logic [DATA_W-1:0] mem_wdata, play_rd, host_rd;
  logic [DATA_W-1:0] play_q, host_rdata_q;
  logic              play_vld_q;

  trig_seq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .mode_i    (seq_mode_e'(mode_i)),
    .loop_i    (loop_i),
    .len_i     (len_i),
    .busy_o    (busy),
    .done_o    (done_o),
    .play_en_o (play_en),
    .rec_we_o  (rec_we),
    .ptr_o     (ptr)
  );

  // host port only while idle; recorder owns the write port during a run
  assign host_ok   = host_en_i & ~busy;
  assign mem_we    = rec_we | (host_ok & host_we_i);
  assign mem_waddr = rec_we ? ptr   : host_addr_i;
  assign mem_wdata = rec_we ? rec_i : host_wdata_i;

  trig_seq_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i     (clk_i),
    .we_i      (mem_we),
    .waddr_i   (mem_waddr),
    .wdata_i   (mem_wdata),
    .raddr_a_i (ptr),
    .rdata_a_o (play_rd),
    .raddr_b_i (host_addr_i),
    .rdata_b_o (host_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      play_q       <= '0;
      play_vld_q   <= 1'b0;
      host_rdata_q <= '0;
    end else begin
      play_q     <= play_en ? play_rd : '0;
      play_vld_q <= play_en;
      if (host_ok && !host_we_i) host_rdata_q <= host_rd;
    end
  end

  assign play_o       = play_q;
  assign play_vld_o   = play_vld_q;
  assign host_rdata_o = host_rdata_q;
  assign busy_o       = busy;
endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              stop_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              play_vld_o,
  input logic [DATA_W-1:0] play_o,
  input logic [DATA_W-1:0] host_rdata_o
);
  p_start_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && !done_o));

  p_done_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  p_vld_in_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    play_vld_o |-> $past(busy_o));

  p_end_flags_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && stop_i) |=> (!busy_o && done_o && !play_vld_o));

  p_host_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(host_rdata_o));

  p_zero_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !play_vld_o |-> (play_o == '0));
endmodule

bind trig_seq_rec trig_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .stop_i       (stop_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .play_vld_o   (play_vld_o),
  .play_o       (play_o),
  .host_rdata_o (host_rdata_o)
);

// File: tb/sim_trig_seq_rec.sv
module sim_trig_seq_rec;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0, rst_n = 1'b0;
  logic              mode = 1'b0, loop = 1'b0, start = 1'b0, stop = 1'b0;
  logic [ADDR_W:0]   len = '0;
  logic [DATA_W-1:0] rec = '0, play, hrdata, hwdata = '0;
  logic              play_vld, busy, done, hen = 1'b0, hwe = 1'b0;
  logic [ADDR_W-1:0] haddr = '0;

  int n_chk = 0, n_fail = 0;
  int exp_mem [DEPTH];
  int last_rd = 0;
  int rv;

  always #(CLK_P/2) clk = ~clk;

  trig_seq_rec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .loop_i(loop), .len_i(len),
    .start_i(start), .stop_i(stop), .rec_i(rec), .play_o(play),
    .play_vld_o(play_vld), .busy_o(busy), .done_o(done),
    .host_en_i(hen), .host_we_i(hwe), .host_addr_i(haddr),
    .host_wdata_i(hwdata), .host_rdata_o(hrdata)
  );

  function automatic int pat(int i, int salt);
    return (i * 37 + salt) & 255;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  task automatic host_wr(input int a, input int d);
    hen = 1'b1; hwe = 1'b1; haddr = ADDR_W'(a); hwdata = DATA_W'(d);
    @(negedge clk);
    hen = 1'b0; hwe = 1'b0;
  endtask

  task automatic host_rd(input int a, output int d);
    hen = 1'b1; hwe = 1'b0; haddr = ADDR_W'(a);
    @(negedge clk);
    hen = 1'b0;
    d = int'(hrdata);
    last_rd = d;
  endtask

  task automatic pulse_start(input bit m, input bit lp, input int l);
    mode = m; loop = lp; len = (ADDR_W+1)'(l);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 && done == 1'b0, "R3 start", int'({busy, done}), 2);
  endtask

  task automatic run_play(input int l, input int n);
    pulse_start(1'b0, 1'b0, l);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(play_vld == 1'b1, "R4 valid", int'(play_vld), 1);
      chk(int'(play) == exp_mem[k], "R4 data", int'(play), exp_mem[k]);
      if (k < n - 1) chk(busy == 1'b1, "R5 busy", int'(busy), 1);
      else chk(busy == 1'b0 && done == 1'b1, "R5 end", int'({busy, done}), 1);
    end
    @(negedge clk);
    chk(play_vld == 1'b0 && play == '0, "R11 idle out", int'(play), 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && play_vld == 0 && play == 0 && hrdata == 0,
        "R1 reset", int'({busy, done, play_vld}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: load and read back every entry
    for (int i = 0; i < DEPTH; i++) begin
      exp_mem[i] = pat(i, 5);
      host_wr(i, exp_mem[i]);
    end
    for (int i = 0; i < DEPTH; i++) begin
      host_rd(i, rv);
      chk(rv == exp_mem[i], "R2 readback", rv, exp_mem[i]);
    end
    chk(int'(hrdata) == last_rd, "R2 hold", int'(hrdata), last_rd);

    // R4/R5: length sweep including 0 and oversize
    run_play(1, 1);
    run_play(3, 3);
    run_play(DEPTH, DEPTH);
    run_play(0, DEPTH);
    run_play(DEPTH + 4, DEPTH);
    chk(done == 1'b1, "R3 done holds", int'(done), 1);

    // R6: record 8 entries
    pulse_start(1'b1, 1'b0, 8);
    rec = DATA_W'(pat(0, 91));
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      rec = DATA_W'(pat(k + 1, 91));
    end
    chk(busy == 1'b0 && done == 1'b1, "R5 record end", int'({busy, done}), 1);
    for (int i = 0; i < 8; i++) exp_mem[i] = pat(i, 91);
    for (int i = 0; i < DEPTH; i++) begin
      host_rd(i, rv);
      chk(rv == exp_mem[i], "R6 recorded", rv, exp_mem[i]);
    end

    // R7: stop after five entries
    pulse_start(1'b0, 1'b0, 0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(int'(play) == exp_mem[k], "R7 pre-stop data", int'(play), exp_mem[k]);
    end
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(busy == 1'b0 && done == 1'b1 && play_vld == 1'b0, "R7 stop",
        int'({busy, done, play_vld}), 2);

    // R8: loop in play mode wraps over three entries
    pulse_start(1'b0, 1'b1, 3);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(play_vld == 1'b1 && int'(play) == exp_mem[k % 3], "R8 wrap",
          int'(play), exp_mem[k % 3]);
    end
    chk(busy == 1'b1, "R8 still running", int'(busy), 1);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(busy == 1'b0 && done == 1'b1, "R8 stop ends loop", int'({busy, done}), 1);

    // R8: loop ignored in record mode
    pulse_start(1'b1, 1'b1, 2);
    rec = DATA_W'(pat(0, 200));
    @(negedge clk);
    rec = DATA_W'(pat(1, 200));
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b1, "R8 record no loop", int'({busy, done}), 1);
    exp_mem[0] = pat(0, 200);
    exp_mem[1] = pat(1, 200);
    host_rd(0, rv);
    chk(rv == exp_mem[0], "R8 record entry0", rv, exp_mem[0]);
    host_rd(2, rv);
    chk(rv == exp_mem[2], "R8 entry2 untouched", rv, exp_mem[2]);

    // R9 and R10: host access and restart during a run
    pulse_start(1'b0, 1'b0, 0);
    for (int k = 0; k < DEPTH; k++) begin
      hen = 1'b0; hwe = 1'b0; start = 1'b0;
      if (k == 2) begin hen = 1'b1; hwe = 1'b1; haddr = 4'd10; hwdata = 8'hAA; end
      if (k == 3) begin hen = 1'b1; hwe = 1'b0; haddr = 4'd0; end
      if (k == 5) start = 1'b1;
      @(negedge clk);
      chk(play_vld == 1'b1 && int'(play) == exp_mem[k], "R10 sequence kept",
          int'(play), exp_mem[k]);
    end
    hen = 1'b0; hwe = 1'b0; start = 1'b0;
    chk(busy == 1'b0 && done == 1'b1, "R10 ends as programmed", int'({busy, done}), 1);
    chk(int'(hrdata) == last_rd, "R9 read ignored", int'(hrdata), last_rd);
    host_rd(10, rv);
    chk(rv == exp_mem[10], "R9 write ignored", rv, exp_mem[10]);

    summary();
  end
endmodule